// File: doc/BRIEF.md
# Two-Level Mapped Interrupt Controller

This block gathers 64 system event inputs and funnels them onto 10 host interrupt lines through two programmable many-to-one stages. In the first stage each event is steered to one of 10 channels. In the second stage each channel is steered to one of the 10 hosts. Every event has its own configuration: enable, polarity, and level or edge capture. Every event also has a pending state that software can set (retrigger) or clear (acknowledge).

For each host, a hardware prioritizer picks the winning pending event. It chooses the lowest-numbered channel that is mapped to the host and has work. Inside that channel it chooses the lowest-numbered event. The winner's index can be read from a per-host register. A host line asserts only when all three of these hold: the global enable is set, that host's enable is set, and the host has a winner.

Configuration uses a flat register port. The port has a write strobe and a word address. Reads return data combinationally from the register state.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset:
  - the global enable (address 0x00, bit 0) and all host enables are 0;
  - every event is disabled, active high (polarity words at 0x08/0x09 read all ones) and level captured (type words at 0x0A/0x0B read 0);
  - all map fields are 0;
  - every host line is low.
- R2: Each map field is 4 bits wide.
  - Event 8k+j is mapped through bits 4j+3..4j of word 0x10+k.
  - Channel 8k+j is mapped through bits 4j+3..4j of word 0x18+k.
- R3: With type bit 0 (level), an event's pending bit equals its polarity-adjusted input one cycle later. An acknowledge leaves the bit set while the input stays active. Pending state reads at 0x0C (events 0-31) and 0x0D (events 32-63).
- R4: With type bit 1 (edge), a rising edge of the adjusted input sets pending one cycle later. The bit then stays set after the input returns idle, until an acknowledge clears it.
- R5: A polarity bit of 0 makes the event active low.
- R6: Writing an event index to 0x02 sets that event's pending bit (retrigger), visible on the next cycle. Writing it to 0x03 clears the bit (acknowledge).
- R7: Per-event enables are set by index at 0x04, cleared by index at 0x05, and read or written as words at 0x06/0x07. A disabled event keeps its pending bit but never drives a host.
- R8: For host h, the register at 0x20+h reports the winner: the lowest-numbered channel mapped to h that has a pending enabled event, and within it the lowest-numbered such event.
  - Bit 31 is the valid flag and bits 5..0 hold the event index.
  - The register reads 0 when there is no candidate.
  - The register does not depend on the enables at 0x00 and 0x01.
- R9: A map field value of 10 or above leaves the event or channel unmapped, so it reaches no host.
- R10: Host line h is high exactly when the global enable is set, host enable h is set and host h has a valid winner. Clearing the global enable drops every line on the next cycle.
- R11: The host enable word at 0x01 (bit h for host h) gates each line individually.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 64 | System event inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| host_irq | output | 10 | Host interrupt lines |

## Verification
The bound checker watches the following properties on every cycle:
- a line can only be high while its host has a valid winner;
- clearing the global enable silences all lines on the next cycle;
- a level event whose input is active is pending on the next cycle, and an edge-captured pending bit only drops on an acknowledge;
- every reported winner is a pending, enabled event;
- a retrigger always lands in the pending state.

Other behaviours depend on ordering and configuration history, so only the bench scenarios can show them:
- which event wins when channels compete on one host;
- that unmapped field values really isolate an event;
- that polarity inversion works;
- that the event 63 and channel 9 field positions are correct.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int unsigned MAP_W           = 4;
    localparam int unsigned FIELDS_PER_WORD = 8;
    localparam int unsigned VALID_BIT       = 31;

    localparam int unsigned A_CTRL      = 0;
    localparam int unsigned A_HOST_EN   = 1;
    localparam int unsigned A_PEND_SET  = 2;
    localparam int unsigned A_PEND_CLR  = 3;
    localparam int unsigned A_EN_SET    = 4;
    localparam int unsigned A_EN_CLR    = 5;
    localparam int unsigned A_EN_BASE   = 6;
    localparam int unsigned A_POL_BASE  = 8;
    localparam int unsigned A_TYPE_BASE = 10;
    localparam int unsigned A_PEND_BASE = 12;
    localparam int unsigned A_EMAP_BASE = 16;
    localparam int unsigned A_CMAP_BASE = 24;
    localparam int unsigned A_HIDX_BASE = 32;
endpackage

// File: rtl/irq_evt_capture.sv
module irq_evt_capture #(
    parameter int unsigned NUM_EVT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic [NUM_EVT-1:0] pol,
    input  logic [NUM_EVT-1:0] typ,
    input  logic [NUM_EVT-1:0] sw_set,
    input  logic [NUM_EVT-1:0] sw_clr,
    output logic [NUM_EVT-1:0] pend
);
    typedef struct packed {
        logic [NUM_EVT-1:0] adj;
        logic [NUM_EVT-1:0] latch;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [NUM_EVT-1:0] adj_now;
    logic [NUM_EVT-1:0] rise;

    always_comb begin
        adj_now     = ~(evt_in ^ pol);
        rise        = adj_now & ~cap_q.adj;
        cap_d.adj   = adj_now;
        // latch: edge capture in edge mode, software flag in both modes
        cap_d.latch = (typ & rise) | sw_set | (cap_q.latch & ~sw_clr);
        pend        = cap_q.latch | (~typ & cap_q.adj);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end
endmodule

// File: rtl/irq_chan_scan.sv
module irq_chan_scan #(
    parameter int unsigned NUM_EVT = 64,
    parameter int unsigned MAP_W   = 4,
    parameter int unsigned CH_ID   = 0,
    localparam int unsigned IDX_W  = $clog2(NUM_EVT)
) (
    input  logic [NUM_EVT-1:0]       elig,
    input  logic [NUM_EVT*MAP_W-1:0] evt_map,
    output logic                     hit,
    output logic [IDX_W-1:0]         first_idx
);
    always_comb begin
        hit       = 1'b0;
        first_idx = '0;
        for (int e = NUM_EVT - 1; e >= 0; e--) begin
            if (elig[e] && (evt_map[e*MAP_W +: MAP_W] == MAP_W'(CH_ID))) begin
                hit       = 1'b1;
                first_idx = IDX_W'(e);
            end
        end
    end
endmodule

// File: rtl/irq_host_pick.sv
module irq_host_pick #(
    parameter int unsigned NUM_CH  = 10,
    parameter int unsigned MAP_W   = 4,
    parameter int unsigned IDX_W   = 6,
    parameter int unsigned HOST_ID = 0
) (
    input  logic [NUM_CH-1:0]       ch_hit,
    input  logic [NUM_CH*IDX_W-1:0] ch_idx,
    input  logic [NUM_CH*MAP_W-1:0] ch_map,
    output logic                    valid,
    output logic [IDX_W-1:0]        idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (ch_hit[c] && (ch_map[c*MAP_W +: MAP_W] == MAP_W'(HOST_ID))) begin
                valid = 1'b1;
                idx   = ch_idx[c*IDX_W +: IDX_W];
            end
        end
    end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_EVT  = 64,
    parameter int unsigned NUM_CH   = 10,
    parameter int unsigned NUM_HOST = 10,
    parameter int unsigned ADDR_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EVT-1:0]  evt_in,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [NUM_HOST-1:0] host_irq
);
    localparam int unsigned IDX_W     = $clog2(NUM_EVT);
    localparam int unsigned EVT_WORDS = NUM_EVT / 32;

    typedef struct packed {
        logic                      glb_en;
        logic [NUM_HOST-1:0]       host_en;
        logic [NUM_EVT-1:0]        evt_en;
        logic [NUM_EVT-1:0]        pol;
        logic [NUM_EVT-1:0]        typ;
        logic [NUM_EVT*MAP_W-1:0]  evt_map;
        logic [NUM_CH*MAP_W-1:0]   ch_map;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        glb_en:  1'b0,
        host_en: '0,
        evt_en:  '0,
        pol:     '1,
        typ:     '0,
        evt_map: '0,
        ch_map:  '0
    };

    cfg_t cfg_d, cfg_q;

    logic [31:0]               addr_x;
    logic [IDX_W-1:0]          wr_idx;
    logic [NUM_EVT-1:0]        idx_onehot;
    logic [NUM_EVT-1:0]        sw_set, sw_clr;
    logic [NUM_EVT-1:0]        pend, elig;
    logic [NUM_EVT-1:0]        pol_w, typ_w;
    logic [NUM_EVT*MAP_W-1:0]  evt_map_w;
    logic [NUM_CH*MAP_W-1:0]   ch_map_w;
    logic [NUM_CH-1:0]         ch_hit;
    logic [NUM_CH*IDX_W-1:0]   ch_idx;
    logic [NUM_HOST-1:0]       host_valid;
    logic [NUM_HOST*IDX_W-1:0] host_idx;

    assign addr_x     = 32'(reg_addr);
    assign wr_idx     = reg_wdata[IDX_W-1:0];
    assign idx_onehot = {{(NUM_EVT-1){1'b0}}, 1'b1} << wr_idx;
    assign pol_w      = cfg_q.pol;
    assign typ_w      = cfg_q.typ;
    assign evt_map_w  = cfg_q.evt_map;
    assign ch_map_w   = cfg_q.ch_map;

    // Register write decode and next configuration state
    always_comb begin
        cfg_d  = cfg_q;
        sw_set = '0;
        sw_clr = '0;
        if (reg_wr) begin
            if (addr_x == A_CTRL)     cfg_d.glb_en  = reg_wdata[0];
            if (addr_x == A_HOST_EN)  cfg_d.host_en = reg_wdata[NUM_HOST-1:0];
            if (addr_x == A_PEND_SET) sw_set        = idx_onehot;
            if (addr_x == A_PEND_CLR) sw_clr        = idx_onehot;
            if (addr_x == A_EN_SET)   cfg_d.evt_en  = cfg_q.evt_en | idx_onehot;
            if (addr_x == A_EN_CLR)   cfg_d.evt_en  = cfg_q.evt_en & ~idx_onehot;
            for (int w = 0; w < EVT_WORDS; w++) begin
                if (addr_x == A_EN_BASE + 32'(w))   cfg_d.evt_en[w*32 +: 32] = reg_wdata;
                if (addr_x == A_POL_BASE + 32'(w))  cfg_d.pol[w*32 +: 32]    = reg_wdata;
                if (addr_x == A_TYPE_BASE + 32'(w)) cfg_d.typ[w*32 +: 32]    = reg_wdata;
            end
            for (int e = 0; e < NUM_EVT; e++) begin
                if (addr_x == A_EMAP_BASE + 32'(e / FIELDS_PER_WORD))
                    cfg_d.evt_map[e*MAP_W +: MAP_W] =
                        reg_wdata[(e % FIELDS_PER_WORD)*MAP_W +: MAP_W];
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (addr_x == A_CMAP_BASE + 32'(c / FIELDS_PER_WORD))
                    cfg_d.ch_map[c*MAP_W +: MAP_W] =
                        reg_wdata[(c % FIELDS_PER_WORD)*MAP_W +: MAP_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (addr_x == A_CTRL)    reg_rdata[0] = cfg_q.glb_en;
        if (addr_x == A_HOST_EN) reg_rdata[NUM_HOST-1:0] = cfg_q.host_en;
        for (int w = 0; w < EVT_WORDS; w++) begin
            if (addr_x == A_EN_BASE + 32'(w))   reg_rdata = cfg_q.evt_en[w*32 +: 32];
            if (addr_x == A_POL_BASE + 32'(w))  reg_rdata = cfg_q.pol[w*32 +: 32];
            if (addr_x == A_TYPE_BASE + 32'(w)) reg_rdata = cfg_q.typ[w*32 +: 32];
            if (addr_x == A_PEND_BASE + 32'(w)) reg_rdata = pend[w*32 +: 32];
        end
        for (int e = 0; e < NUM_EVT; e++) begin
            if (addr_x == A_EMAP_BASE + 32'(e / FIELDS_PER_WORD))
                reg_rdata[(e % FIELDS_PER_WORD)*MAP_W +: MAP_W] =
                    cfg_q.evt_map[e*MAP_W +: MAP_W];
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr_x == A_CMAP_BASE + 32'(c / FIELDS_PER_WORD))
                reg_rdata[(c % FIELDS_PER_WORD)*MAP_W +: MAP_W] =
                    cfg_q.ch_map[c*MAP_W +: MAP_W];
        end
        for (int h = 0; h < NUM_HOST; h++) begin
            if (addr_x == A_HIDX_BASE + 32'(h)) begin
                reg_rdata[VALID_BIT]   = host_valid[h];
                reg_rdata[IDX_W-1:0]   = host_idx[h*IDX_W +: IDX_W];
            end
        end
    end

    irq_evt_capture #(.NUM_EVT(NUM_EVT)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_in (evt_in),
        .pol    (pol_w),
        .typ    (typ_w),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .pend   (pend)
    );

    assign elig = pend & cfg_q.evt_en;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        irq_chan_scan #(
            .NUM_EVT (NUM_EVT),
            .MAP_W   (MAP_W),
            .CH_ID   (c)
        ) u_scan (
            .elig      (elig),
            .evt_map   (evt_map_w),
            .hit       (ch_hit[c]),
            .first_idx (ch_idx[c*IDX_W +: IDX_W])
        );
    end

    for (genvar h = 0; h < NUM_HOST; h++) begin : g_host
        irq_host_pick #(
            .NUM_CH  (NUM_CH),
            .MAP_W   (MAP_W),
            .IDX_W   (IDX_W),
            .HOST_ID (h)
        ) u_pick (
            .ch_hit (ch_hit),
            .ch_idx (ch_idx),
            .ch_map (ch_map_w),
            .valid  (host_valid[h]),
            .idx    (host_idx[h*IDX_W +: IDX_W])
        );
    end

    assign host_irq = {NUM_HOST{cfg_q.glb_en}} & cfg_q.host_en & host_valid;
endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_EVT  = 64,
    parameter int unsigned NUM_HOST = 10,
    parameter int unsigned ADDR_W   = 6,
    localparam int unsigned IDX_W   = $clog2(NUM_EVT)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_EVT-1:0]       evt_in,
    input logic                     reg_wr,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [31:0]              reg_wdata,
    input logic [NUM_HOST-1:0]      host_irq,
    input logic [NUM_EVT-1:0]       pol,
    input logic [NUM_EVT-1:0]       typ,
    input logic [NUM_EVT-1:0]       pend,
    input logic [NUM_EVT-1:0]       sw_clr,
    input logic [NUM_EVT-1:0]       elig,
    input logic [NUM_HOST-1:0]      host_valid,
    input logic [NUM_HOST*IDX_W-1:0] host_idx
);
    AST_GLB_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (32'(reg_addr) == A_CTRL) && !reg_wdata[0]) |=> (host_irq == '0)); // R10

    AST_IRQ_NEEDS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq & ~host_valid) == '0); // R10

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(typ) && $stable(pol)) |->
            (($past(~(evt_in ^ pol) & ~typ) & ~pend) == '0)); // R3

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(typ) |-> (($past(pend & typ & ~sw_clr) & ~pend) == '0)); // R4

    AST_RETRIG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (32'(reg_addr) == A_PEND_SET)) |=>
            pend[$past(reg_wdata[IDX_W-1:0])]); // R6

    for (genvar h = 0; h < NUM_HOST; h++) begin : g_win
        AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
            host_valid[h] |-> elig[host_idx[h*IDX_W +: IDX_W]]); // R8
    end
endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(
    .NUM_EVT  (NUM_EVT),
    .NUM_HOST (NUM_HOST),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_in     (evt_in),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .host_irq   (host_irq),
    .pol        (pol_w),
    .typ        (typ_w),
    .pend       (pend),
    .sw_clr     (sw_clr),
    .elig       (elig),
    .host_valid (host_valid),
    .host_idx   (host_idx)
);

// File: tb/irq_route_ctrl_tb.sv
module irq_route_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_IN = 2'd2, K_IRQ = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 60;
    localparam step_t STEPS [NSTEP] = '{
        '{K_RD,  6'h00, 32'h0000_0000, 4'd1},  // R1 global enable off
        '{K_RD,  6'h08, 32'hFFFF_FFFF, 4'd1},  // R1 active high
        '{K_RD,  6'h0B, 32'h0000_0000, 4'd1},  // R1 level
        '{K_RD,  6'h10, 32'h0000_0000, 4'd1},  // R1 map zero
        '{K_IRQ, 6'h00, 32'h0000_0000, 4'd1},  // R1 lines low
        '{K_WR,  6'h00, 32'h0000_0001, 4'd10}, // R10
        '{K_WR,  6'h01, 32'h0000_03FF, 4'd11}, // R11
        '{K_WR,  6'h10, 32'h0000_2000, 4'd2},  // R2 event 3 -> ch2
        '{K_WR,  6'h18, 32'h0000_0500, 4'd2},  // R2 ch2 -> host5
        '{K_WR,  6'h04, 32'h0000_0003, 4'd7},  // R7
        '{K_RD,  6'h06, 32'h0000_0008, 4'd7},  // R7
        '{K_IN,  6'd3,  32'h1,         4'd3},  // R3
        '{K_IRQ, 6'h00, 32'h0000_0020, 4'd3},  // R3
        '{K_RD,  6'h25, 32'h8000_0003, 4'd8},  // R8
        '{K_RD,  6'h0C, 32'h0000_0008, 4'd3},  // R3
        '{K_IN,  6'd3,  32'h0,         4'd3},  // R3
        '{K_IRQ, 6'h00, 32'h0000_0000, 4'd3},  // R3
        '{K_IN,  6'd3,  32'h1,         4'd3},  // R3
        '{K_WR,  6'h03, 32'h0000_0003, 4'd3},  // R3 ack while active
        '{K_RD,  6'h0C, 32'h0000_0008, 4'd3},  // R3
        '{K_IN,  6'd3,  32'h0,         4'd3},  // R3
        '{K_WR,  6'h0A, 32'h0000_0008, 4'd4},  // R4 edge mode
        '{K_RD,  6'h0C, 32'h0000_0000, 4'd4},  // R4
        '{K_IN,  6'd3,  32'h1,         4'd4},  // R4
        '{K_IN,  6'd3,  32'h0,         4'd4},  // R4
        '{K_RD,  6'h0C, 32'h0000_0008, 4'd4},  // R4 sticky
        '{K_IRQ, 6'h00, 32'h0000_0020, 4'd4},  // R4
        '{K_WR,  6'h03, 32'h0000_0003, 4'd4},  // R4
        '{K_RD,  6'h0C, 32'h0000_0000, 4'd4},  // R4
        '{K_WR,  6'h02, 32'h0000_0003, 4'd6},  // R6
        '{K_RD,  6'h0C, 32'h0000_0008, 4'd6},  // R6
        '{K_WR,  6'h03, 32'h0000_0003, 4'd6},  // R6
        '{K_IRQ, 6'h00, 32'h0000_0000, 4'd6},  // R6
        '{K_WR,  6'h02, 32'h0000_0003, 4'd10}, // R10
        '{K_WR,  6'h00, 32'h0000_0000, 4'd10}, // R10
        '{K_IRQ, 6'h00, 32'h0000_0000, 4'd10}, // R10
        '{K_RD,  6'h25, 32'h8000_0003, 4'd8},  // R8
        '{K_WR,  6'h00, 32'h0000_0001, 4'd10}, // R10
        '{K_IRQ, 6'h00, 32'h0000_0020, 4'd10}, // R10
        '{K_WR,  6'h01, 32'h0000_03DF, 4'd11}, // R11
        '{K_IRQ, 6'h00, 32'h0000_0000, 4'd11}, // R11
        '{K_WR,  6'h01, 32'h0000_03FF, 4'd11}, // R11
        '{K_WR,  6'h05, 32'h0000_0003, 4'd7},  // R7
        '{K_IRQ, 6'h00, 32'h0000_0000, 4'd7},  // R7
        '{K_RD,  6'h0C, 32'h0000_0008, 4'd7},  // R7
        '{K_WR,  6'h04, 32'h0000_0003, 4'd7},  // R7
        '{K_WR,  6'h10, 32'h0000_2020, 4'd8},  // R8 event 1 -> ch2
        '{K_WR,  6'h04, 32'h0000_0001, 4'd8},  // R8
        '{K_WR,  6'h02, 32'h0000_0001, 4'd8},  // R8
        '{K_RD,  6'h25, 32'h8000_0001, 4'd8},  // R8 lowest event
        '{K_WR,  6'h15, 32'h0000_0001, 4'd8},  // R8 event 40 -> ch1
        '{K_WR,  6'h18, 32'h0000_0550, 4'd8},  // R8 ch1 -> host5
        '{K_WR,  6'h04, 32'h0000_0028, 4'd8},  // R8
        '{K_WR,  6'h02, 32'h0000_0028, 4'd8},  // R8
        '{K_RD,  6'h25, 32'h8000_0028, 4'd8},  // R8 lowest channel wins
        '{K_WR,  6'h18, 32'h0000_05A0, 4'd9},  // R9 ch1 -> 10
        '{K_RD,  6'h25, 32'h8000_0001, 4'd9},  // R9
        '{K_WR,  6'h10, 32'h0000_F0F0, 4'd9},  // R9 events 1,3 -> 15
        '{K_RD,  6'h25, 32'h0000_0000, 4'd9},  // R9
        '{K_IRQ, 6'h00, 32'h0000_0000, 4'd9}   // R9
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] evt_in;
    logic        reg_wr;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [9:0]  host_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_route_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .host_irq  (host_irq)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
    endtask

    task automatic rd(input int req, input logic [5:0] a, input logic [31:0] exp_v);
        @(negedge clk);
        reg_wr   = 1'b0;
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp_v);
    endtask

    task automatic setin(input int idx, input logic v);
        @(negedge clk);
        reg_wr      = 1'b0;
        evt_in[idx] = v;
    endtask

    task automatic idle();
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; evt_in = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NSTEP; i++) begin
            @(negedge clk);
            reg_wr = 1'b0;
            case (STEPS[i].kind)
                K_WR: begin
                    reg_wr    = 1'b1;
                    reg_addr  = STEPS[i].addr;
                    reg_wdata = STEPS[i].data;
                end
                K_RD: begin
                    reg_addr = STEPS[i].addr;
                    #1;
                    check(int'(STEPS[i].req), reg_rdata, STEPS[i].data);
                end
                K_IN: evt_in[STEPS[i].addr] = STEPS[i].data[0];
                default: begin
                    #1;
                    check(int'(STEPS[i].req), {22'b0, host_irq}, STEPS[i].data);
                end
            endcase
        end

        // R5: active-low polarity on event 3 (level), back on ch2 -> host5
        wr(6'h10, 32'h0000_2000);
        wr(6'h03, 32'd3);
        wr(6'h0A, 32'h0);
        wr(6'h08, 32'hFFFF_FFF7);
        idle();
        rd(5, 6'h0C, 32'h0000_000A);   // R5 event 3 via low input, event 1 latched
        rd(5, 6'h25, 32'h8000_0003);   // R5
        setin(3, 1'b1);
        idle();
        rd(5, 6'h0C, 32'h0000_0002);   // R5 high input is idle now
        wr(6'h08, 32'hFFFF_FFFF);

        // R2/R4 boundary: event 63 edge, ch9 -> host9
        wr(6'h17, 32'h9000_0000);
        wr(6'h19, 32'h0000_0090);
        wr(6'h04, 32'd63);
        wr(6'h0B, 32'h8000_0000);
        setin(63, 1'b1);
        rd(2, 6'h29, 32'h8000_003F);   // R2 top fields decoded
        check(4, {31'b0, host_irq[9]}, 32'd1); // R4
        setin(63, 1'b0);
        idle();
        rd(4, 6'h29, 32'h8000_003F);   // R4 still pending
        wr(6'h03, 32'd63);
        rd(4, 6'h29, 32'h0000_0000);   // R4 acknowledged
        #1;
        check(4, {31'b0, host_irq[9]}, 32'd0); // R4

        // R1: reset in the middle of activity
        @(negedge clk);
        reg_wr = 1'b0; evt_in = '0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(1, 6'h01, 32'h0);           // R1 host enables
        rd(1, 6'h06, 32'h0);           // R1 event enables
        rd(1, 6'h0C, 32'h0);           // R1 pending
        rd(1, 6'h18, 32'h0);           // R1 channel map
        rd(1, 6'h09, 32'hFFFF_FFFF);   // R1 polarity high word
        check(1, {22'b0, host_irq}, 32'h0); // R1

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R0: watchdog actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule